// File: doc/BRIEF.md
# Serial Line Idle Detector

This block decides when one direction of a serial port has gone quiet. It measures quiet time in whole bit periods, counting a one-cycle tick that the baud generator issues once per bit. When the measured quiet time reaches a programmable 8-bit threshold, a sticky idle flag is raised. An optional interrupt follows the flag.

Two idle conditions are offered. In the first, the raw line level must stay at logic one. In the second, the serial state machine must report that it is idle. The same block can be placed beside a receiver or beside a transmitter. On the transmit side, the flag marks the moment the last frame has really left the pin, which is later than the transmit buffer running empty. Any break in the selected condition restarts the measurement. After the flag has fired, the detector stays quiet until activity is seen again, so one quiet period produces exactly one event.

Top module: `idle_watch`

## Requirements
- R1: After a synchronous reset, `idle_flag` and `idle_irq` are 0, the count is zero and the detector is armed.
- R2: With `cond_sel`=0 and `det_en`=1, each `bit_tick` cycle during which `line_in` is 1 adds one to the count. `idle_flag` rises on the clock edge of the tick that brings the count to `thresh`. It is therefore visible one cycle after that tick. A threshold of 0 behaves like 1.
- R3: With `cond_sel`=1, the condition is `fsm_idle`=1, and `line_in` has no effect on counting or on the flag.
- R4: In any cycle where the selected condition is 0, the count returns to zero. The threshold must then be reached again from zero.
- R5: `idle_flag` keeps its value until `flag_clr` is 1 in a cycle. It reads 0 on the next cycle. When a set and a clear fall on the same edge, the set wins.
- R6: Once the flag has set, the detector is disarmed. It re-arms only when the selected condition is seen at 0 while the flag is already 0, so a continuing quiet period after a clear cannot set the flag again.
- R7: While `det_en`=0, the count is held at zero and the flag cannot rise. An existing flag keeps its value, and the detector is re-armed.
- R8: `idle_irq` equals `idle_flag` AND `irq_en`. `irq_en` has no influence on the flag itself.
- R9: With `cond_sel`=0, `fsm_idle` has no effect on counting or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Detection enable |
| irq_en | input | 1 | Interrupt enable |
| cond_sel | input | 1 | 0: line held high, 1: state machine idle |
| thresh | input | 8 | Idle threshold in bit periods |
| line_in | input | 1 | Serial line level |
| fsm_idle | input | 1 | Serial state machine reports idle |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| flag_clr | input | 1 | Clear of the idle flag |
| idle_flag | output | 1 | Sticky idle indication |
| idle_irq | output | 1 | Idle interrupt request |

## Verification
The directed patterns cover several cases. A steady high line is driven with exact tick counts, which separates one tick short of the threshold from the threshold reached. A single low cycle inserted mid-count checks that the count restarts rather than pauses. A long quiet stretch after a clear checks that the detector stays disarmed. Each condition is driven with the other condition's input toggled, to show that only the selected source matters. Further cases cover threshold zero, a clear that coincides with a set, and detection turned off. Random stretches then mix sparse line glitches, ticks, small thresholds, enable changes and clears. These are compared cycle by cycle with a bench model, which exposes off-by-one and priority mistakes that the directed cases might miss.

// File: rtl/idlw_pkg.sv
package idlw_pkg;

    localparam int unsigned THR_W = 8;

    typedef enum logic {
        COND_LINE_HIGH = 1'b0,
        COND_FSM_IDLE  = 1'b1
    } idle_cond_e;

    typedef struct packed {
        logic       en;
        idle_cond_e sel;
        logic [THR_W-1:0] thr;
    } det_cfg_t;

    // zero threshold acts as a single bit period
    function automatic logic [THR_W-1:0] eff_thr(input logic [THR_W-1:0] t);
        return (t == '0) ? {{(THR_W-1){1'b0}}, 1'b1} : t;
    endfunction

    function automatic logic pick_cond(input idle_cond_e s, input logic line, input logic fsm);
        return (s == COND_FSM_IDLE) ? fsm : line;
    endfunction

endpackage

// File: rtl/idlw_cond_mux.sv
module idlw_cond_mux
    import idlw_pkg::*;
(
    input  det_cfg_t cfg,
    input  logic     line_in,
    input  logic     fsm_idle,
    output logic     cond_ok
);
    always_comb begin
        cond_ok = cfg.en & pick_cond(cfg.sel, line_in, fsm_idle);
    end
endmodule

// File: rtl/idlw_bit_counter.sv
module idlw_bit_counter
    import idlw_pkg::*;
#(
    parameter int unsigned W = THR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cond_ok,
    input  logic         armed,
    input  logic         bit_tick,
    input  logic [W-1:0] thr,
    output logic [W-1:0] cnt,
    output logic         reached
);
    localparam int unsigned CW = W + 1;

    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] thr_ext;

    always_comb begin
        cnt_inc = {1'b0, cnt} + CW'(1);
        thr_ext = {1'b0, eff_thr(thr)};
        reached = cond_ok & armed & bit_tick & (cnt_inc >= thr_ext);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!cond_ok || !armed || reached) begin
            cnt <= '0;
        end else if (bit_tick) begin
            cnt <= cnt_inc[W-1:0];
        end
    end
endmodule

// File: rtl/idlw_flag_ctl.sv
module idlw_flag_ctl
    import idlw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic cond_ok,
    input  logic reached,
    input  logic flag_clr,
    output logic armed,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (reached) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end else if (!en) begin
            armed <= 1'b1;
        end else if (reached) begin
            armed <= 1'b0;
        end else if (!cond_ok && !flag) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/idle_watch.sv
module idle_watch
    import idlw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             det_en,
    input  logic             irq_en,
    input  logic             cond_sel,
    input  logic [THR_W-1:0] thresh,
    input  logic             line_in,
    input  logic             fsm_idle,
    input  logic             bit_tick,
    input  logic             flag_clr,
    output logic             idle_flag,
    output logic             idle_irq
);
    det_cfg_t         cfg;
    logic             cond_ok;
    logic             armed;
    logic             reached;
    logic [THR_W-1:0] cnt;

    always_comb begin
        cfg.en  = det_en;
        cfg.sel = idle_cond_e'(cond_sel);
        cfg.thr = thresh;
    end

    idlw_cond_mux u_cond (
        .cfg      (cfg),
        .line_in  (line_in),
        .fsm_idle (fsm_idle),
        .cond_ok  (cond_ok)
    );

    idlw_bit_counter #(.W(THR_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cond_ok  (cond_ok),
        .armed    (armed),
        .bit_tick (bit_tick),
        .thr      (cfg.thr),
        .cnt      (cnt),
        .reached  (reached)
    );

    idlw_flag_ctl u_flag (
        .clk      (clk),
        .rst      (rst),
        .en       (det_en),
        .cond_ok  (cond_ok),
        .reached  (reached),
        .flag_clr (flag_clr),
        .armed    (armed),
        .flag     (idle_flag)
    );

    assign idle_irq = idle_flag & irq_en;
endmodule

// File: rtl/idlw_checker.sv
module idlw_checker
    import idlw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             det_en,
    input logic             bit_tick,
    input logic             flag_clr,
    input logic             idle_flag,
    input logic             cond_ok,
    input logic [THR_W-1:0] cnt
);
    // R2: a new flag only follows a tick
    assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_flag) |-> $past(bit_tick));

    // R4: a broken condition restarts the count
    assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
        !cond_ok |=> (cnt == '0));

    // R5: sticky without clear
    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (idle_flag && !flag_clr) |=> idle_flag);

    // R5: clear with no tick empties the flag
    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !bit_tick) |=> !idle_flag);

    // R7: disabled detector never raises the flag
    assert_no_rise_off_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_flag) |-> $past(det_en));

    // R7: disabled detector holds zero count
    assert_hold_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> (cnt == '0));
endmodule

bind idle_watch idlw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .det_en    (det_en),
    .bit_tick  (bit_tick),
    .flag_clr  (flag_clr),
    .idle_flag (idle_flag),
    .cond_ok   (cond_ok),
    .cnt       (cnt)
);

// File: tb/tb_idle_watch.sv
module tb_idle_watch;
    logic       clk = 1'b0;
    logic       rst;
    logic       det_en, irq_en, cond_sel, line_in, fsm_idle, bit_tick, flag_clr;
    logic [7:0] thresh;
    logic       idle_flag, idle_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    idle_watch dut (
        .clk(clk), .rst(rst), .det_en(det_en), .irq_en(irq_en),
        .cond_sel(cond_sel), .thresh(thresh), .line_in(line_in),
        .fsm_idle(fsm_idle), .bit_tick(bit_tick), .flag_clr(flag_clr),
        .idle_flag(idle_flag), .idle_irq(idle_irq)
    );

    // bench model state
    logic       m_flag;
    logic       m_armed;
    int         m_cnt;

    function automatic logic exp_cond(input logic sel, input logic ln, input logic fs);
        return sel ? fs : ln;
    endfunction

    function automatic int exp_thr(input logic [7:0] t);
        return (t == 8'd0) ? 1 : int'(t);
    endfunction

    always @(posedge clk) begin
        logic c, hit;
        if (rst) begin
            m_flag = 1'b0; m_armed = 1'b1; m_cnt = 0;
        end else begin
            c   = det_en && exp_cond(cond_sel, line_in, fsm_idle);
            hit = c && m_armed && bit_tick && (m_cnt + 1 >= exp_thr(thresh));
            if (!det_en)                m_armed = 1'b1;
            else if (hit)               m_armed = 1'b0;
            else if (!c && !m_flag)     m_armed = 1'b1;
            if (hit)                    m_flag = 1'b1;
            else if (flag_clr)          m_flag = 1'b0;
            if (!c || hit || !(m_armed || hit)) m_cnt = 0;
            else if (bit_tick)          m_cnt = m_cnt + 1;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; step();
            bit_tick = 1'b0; step();
        end
    endtask

    task automatic clear();
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; det_en = 1'b1; irq_en = 1'b1; cond_sel = 1'b0;
        thresh = 8'd3; line_in = 1'b1; fsm_idle = 1'b0; bit_tick = 1'b0; flag_clr = 1'b0;
        @(negedge clk); step(); step();
        rst = 1'b0;
        check("R1 flag", idle_flag, 1'b0);
        check("R1 irq", idle_irq, 1'b0);

        // R2: exact count
        pulse(2);
        check("R2 below threshold", idle_flag, 1'b0);
        bit_tick = 1'b1; step(); bit_tick = 1'b0;
        check("R2 reached", idle_flag, 1'b1);
        check("R8 irq follows", idle_irq, 1'b1);
        pulse(3);
        check("R5 sticky", idle_flag, 1'b1);
        irq_en = 1'b0; step();
        check("R8 irq masked", idle_irq, 1'b0);
        check("R8 flag kept", idle_flag, 1'b1);
        irq_en = 1'b1;
        clear();
        check("R5 cleared", idle_flag, 1'b0);

        // R6: still quiet, no re-fire
        pulse(6);
        check("R6 disarmed", idle_flag, 1'b0);

        // R4: restart after a glitch
        line_in = 1'b0; step(); line_in = 1'b1;
        pulse(2);
        line_in = 1'b0; step(); line_in = 1'b1;
        pulse(2);
        check("R4 restarted", idle_flag, 1'b0);
        pulse(1);
        check("R4 full count", idle_flag, 1'b1);

        // R9: fsm_idle ignored in line mode
        clear();
        fsm_idle = 1'b0; step(); fsm_idle = 1'b1; step(); fsm_idle = 1'b0;
        pulse(4);
        check("R9 fsm ignored", idle_flag, 1'b0);

        // R3: state machine condition, line toggled
        cond_sel = 1'b1; fsm_idle = 1'b0; step();
        fsm_idle = 1'b1; thresh = 8'd2;
        line_in = 1'b0; pulse(1); line_in = 1'b1; step(); line_in = 1'b0;
        check("R3 one tick", idle_flag, 1'b0);
        pulse(1);
        check("R3 reached", idle_flag, 1'b1);
        line_in = 1'b1;

        // R2: threshold zero acts as one; R5 set beats clear
        cond_sel = 1'b0; thresh = 8'd0;
        clear();
        line_in = 1'b0; step(); line_in = 1'b1;
        bit_tick = 1'b1; flag_clr = 1'b1; step(); bit_tick = 1'b0; flag_clr = 1'b0;
        check("R5 set wins", idle_flag, 1'b1);
        check("R2 zero threshold", idle_flag, 1'b1);

        // R7: disabled
        det_en = 1'b0; step();
        check("R7 flag held", idle_flag, 1'b1);
        clear();
        pulse(5);
        check("R7 no set", idle_flag, 1'b0);
        det_en = 1'b1; thresh = 8'd2;
        pulse(2);
        check("R7 re-enabled", idle_flag, 1'b1);

        // random mix compared with the model (R2..R9)
        void'($urandom(32'd1234));
        for (int k = 0; k < 4000; k++) begin
            bit_tick = (($urandom % 3) == 0);
            if (($urandom % 16) == 0) line_in  = ~line_in;
            else if (($urandom % 4) == 0) line_in = 1'b1;
            if (($urandom % 12) == 0) fsm_idle = ~fsm_idle;
            flag_clr = (($urandom % 40) == 0);
            if (($urandom % 200) == 0) cond_sel = ~cond_sel;
            if (($urandom % 150) == 0) det_en = ~det_en;
            if (($urandom % 100) == 0) irq_en = ~irq_en;
            if (($urandom % 120) == 0) thresh = 8'($urandom % 6);
            step();
            check("R2 model flag", idle_flag, m_flag);
            check("R8 model irq", idle_irq, m_flag & irq_en);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule